// File: doc/BRIEF.md
# Direct-Store Segment Access Checker

This block decides the outcome of a memory access that lands in a segment marked for direct-store (I/O controller) handling. Each cycle it may take one request: the 32-bit segment descriptor, the effective address, the access kind, the instruction class that issued the access and whether the processor is in user mode. One clock later it presents the result. A result is either a translated address with success flags, or a fault with an exception class, a 32-bit status word and the faulting address.

One bus-unit identifier in the descriptor selects a memory-forced path. That path skips every protection check and builds the physical address from a 4-bit region field and the low 28 address bits. Every other direct-store access goes through a fixed order of checks. Instruction fetches are refused first. After that, each instruction class has its own outcome: ordinary integer accesses are gated by a privilege key, cache-management operations complete as no-ops, and the remaining classes fault with status codes of their own.

Encodings used throughout: the access kind is 0 = load, 1 = store, 2 = fetch, and 3 is treated as a load. The instruction class is 0 = integer, 1 = floating point, 2 = reservation, 3 = cache management, 4 = external control, and 5 to 7 are undefined. The fault class is 0 = none, 1 = instruction access, 2 = data access, 3 = alignment, 4 = illegal operation. In the descriptor, bit 30 is the supervisor key, bit 29 is the user key, bits 28:20 are the bus-unit identifier and bits 3:0 are the region.

Top module: `ds_seg_checker`

## Requirements
- R1: When descriptor bits 28:20 equal 0x07F, the result is `phys_addr` = {descriptor bits 3:0, address bits 27:0} with `full_access` = 1, `fault` = 0 and `ds_ok` = 0, whatever the access kind, class or key.
- R2: Otherwise a fetch (kind 2) faults with class 1 (instruction access) and status 0x10000000, whatever the instruction class.
- R3: A non-fetch floating-point access (class 1) faults with class 3 (alignment) and status 0x00000000.
- R4: A reservation access (class 2) faults with class 2 (data access) and status 0x04000000 for a load, or 0x06000000 for a store.
- R5: An external-control access (class 4) faults with class 2 and status 0x04100000 for a load, or 0x06100000 for a store.
- R6: A cache-management access (class 3) completes with no fault, `phys_addr` equal to the effective address, and `ds_ok` = 0 and `full_access` = 0.
- R7: The key is descriptor bit 29 when `user_mode` = 1, and descriptor bit 30 otherwise.
- R8: An integer access (class 0) succeeds when it is a load with key 0 or a store with key 1. Success gives `ds_ok` = 1 and `phys_addr` equal to the effective address. Any other integer access faults with class 2 and status 0x08000000 for a load, or 0x0A000000 for a store.
- R9: A non-fetch access with an undefined class (5 to 7) faults with class 4 (illegal operation) and status 0x00000000.
- R10: Results appear one clock after the request, with `out_valid` following `in_valid`. Whenever `fault` = 1, `phys_addr` is 0 and `fault_addr` holds the effective address. Without a fault, `fault_addr` is 0. While `out_valid` = 0 or reset is active, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| seg_reg | input | 32 | Segment descriptor of the accessed segment |
| eff_addr | input | 32 | Effective address |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| instr_class | input | 3 | Issuing instruction class |
| user_mode | input | 1 | 1 for a user-mode access |
| out_valid | output | 1 | Result present |
| phys_addr | output | 32 | Translated address |
| full_access | output | 1 | Memory-forced path taken, all rights granted |
| ds_ok | output | 1 | Integer direct-store access granted |
| fault | output | 1 | Access refused |
| fault_class | output | 3 | Exception class of the fault |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Faulting effective address |

## Verification
Requests are issued back to back so that every class meets every access kind where it matters. The bypass identifier is paired with a fetch and a floating-point request, which shows that it overrides all later checks. The neighbouring identifier 0x07E shows that the match is exact. Integer requests cover both privilege levels with the two key bits set to opposite values, so a wrong key choice gives the wrong grant. Fetches with cache and integer classes show that the fetch refusal comes before the class decode.

// File: rtl/ds_pkg.sv
package ds_pkg;

    localparam int ADDR_W   = 32;
    localparam int SEG_W    = 32;
    localparam int KIND_W   = 2;
    localparam int CLASS_W  = 3;
    localparam int FCLS_W   = 3;

    typedef enum logic [KIND_W-1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_kind_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_INT   = 3'd0,
        CLS_FLOAT = 3'd1,
        CLS_RESV  = 3'd2,
        CLS_CACHE = 3'd3,
        CLS_EXT   = 3'd4,
        CLS_U5    = 3'd5,
        CLS_U6    = 3'd6,
        CLS_U7    = 3'd7
    } instr_cls_e;

    typedef enum logic [FCLS_W-1:0] {
        FLT_NONE    = 3'd0,
        FLT_INSN    = 3'd1,
        FLT_DATA    = 3'd2,
        FLT_ALIGN   = 3'd3,
        FLT_ILLEGAL = 3'd4
    } fault_cls_e;

    localparam logic [31:0] ST_FETCH      = 32'h1000_0000;
    localparam logic [31:0] ST_RESV_LD    = 32'h0400_0000;
    localparam logic [31:0] ST_RESV_ST    = 32'h0600_0000;
    localparam logic [31:0] ST_EXT_LD     = 32'h0410_0000;
    localparam logic [31:0] ST_EXT_ST     = 32'h0610_0000;
    localparam logic [31:0] ST_PROT_LD    = 32'h0800_0000;
    localparam logic [31:0] ST_PROT_ST    = 32'h0A00_0000;
    localparam logic [31:0] ST_NONE       = 32'h0000_0000;

    typedef struct packed {
        logic [ADDR_W-1:0] phys;
        logic              full;
        logic              ds_ok;
        logic              fault;
        fault_cls_e        fcls;
        logic [31:0]       fstat;
        logic [ADDR_W-1:0] faddr;
    } ds_result_t;

    function automatic ds_result_t make_fault(fault_cls_e c, logic [31:0] st,
                                              logic [ADDR_W-1:0] ea);
        ds_result_t r;
        r       = '0;
        r.fault = 1'b1;
        r.fcls  = c;
        r.fstat = st;
        r.faddr = ea;
        return r;
    endfunction

    function automatic ds_result_t make_pass(logic [ADDR_W-1:0] pa);
        ds_result_t r;
        r      = '0;
        r.phys = pa;
        return r;
    endfunction

endpackage

// File: rtl/ds_key_select.sv
module ds_key_select
    import ds_pkg::*;
#(
    parameter int SUP_KEY_BIT  = 30,
    parameter int USER_KEY_BIT = 29
) (
    input  logic [SEG_W-1:0] seg,
    input  logic             user_mode,
    output logic             key
);
    always_comb begin
        key = user_mode ? seg[USER_KEY_BIT] : seg[SUP_KEY_BIT];
    end
endmodule

// File: rtl/ds_classify.sv
module ds_classify
    import ds_pkg::*;
#(
    parameter int          BUS_HI    = 28,
    parameter int          BUS_LO    = 20,
    parameter logic [8:0]  BYPASS_ID = 9'h07F,
    parameter int          REGION_W  = 4
) (
    input  logic [SEG_W-1:0]   seg,
    input  logic [ADDR_W-1:0]  ea,
    input  logic [KIND_W-1:0]  kind_raw,
    input  logic [CLASS_W-1:0] cls_raw,
    input  logic               key,
    output ds_result_t         res
);
    localparam int BUS_W  = BUS_HI - BUS_LO + 1;
    localparam int LOW_W  = ADDR_W - REGION_W;

    acc_kind_e  kind;
    instr_cls_e cls;
    logic       is_store;
    logic       bypass;

    always_comb begin
        kind     = acc_kind_e'(kind_raw);
        cls      = instr_cls_e'(cls_raw);
        is_store = (kind == ACC_STORE);
        bypass   = (seg[BUS_HI:BUS_LO] == BYPASS_ID[BUS_W-1:0]);
    end

    always_comb begin
        res = '0;
        if (bypass) begin
            res.phys = {seg[REGION_W-1:0], ea[LOW_W-1:0]};
            res.full = 1'b1;
        end else if (kind == ACC_FETCH) begin
            res = make_fault(FLT_INSN, ST_FETCH, ea);
        end else begin
            case (cls)
                CLS_INT: begin
                    if ((is_store && key) || (!is_store && !key)) begin
                        res       = make_pass(ea);
                        res.ds_ok = 1'b1;
                    end else begin
                        res = make_fault(FLT_DATA, is_store ? ST_PROT_ST : ST_PROT_LD, ea);
                    end
                end
                CLS_FLOAT: res = make_fault(FLT_ALIGN, ST_NONE, ea);
                CLS_RESV:  res = make_fault(FLT_DATA, is_store ? ST_RESV_ST : ST_RESV_LD, ea);
                CLS_CACHE: res = make_pass(ea);
                CLS_EXT:   res = make_fault(FLT_DATA, is_store ? ST_EXT_ST : ST_EXT_LD, ea);
                default:   res = make_fault(FLT_ILLEGAL, ST_NONE, ea);
            endcase
        end
    end

    // R1 / R10: the bypass path never yields a fault, and no result is both granted and refused
    always_comb begin
        assert_bypass_clean_R1: assert (!(bypass && res.fault));
        assert_grant_excl_R10: assert (!(res.fault && (res.ds_ok || res.full)));
    end
endmodule

// File: rtl/ds_out_reg.sv
module ds_out_reg
    import ds_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  ds_result_t d,
    output logic       q_valid,
    output ds_result_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= in_valid;
            q       <= in_valid ? d : '0;
        end
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> (!q.fault && !q.ds_ok && !q.full && q.phys == '0));
endmodule

// File: rtl/ds_seg_checker.sv
module ds_seg_checker
    import ds_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] seg_reg,
    input  logic [31:0] eff_addr,
    input  logic [1:0]  acc_kind,
    input  logic [2:0]  instr_class,
    input  logic        user_mode,
    output logic        out_valid,
    output logic [31:0] phys_addr,
    output logic        full_access,
    output logic        ds_ok,
    output logic        fault,
    output logic [2:0]  fault_class,
    output logic [31:0] fault_status,
    output logic [31:0] fault_addr
);
    logic       key;
    ds_result_t comb_res;
    ds_result_t reg_res;

    ds_key_select u_key (
        .seg       (seg_reg),
        .user_mode (user_mode),
        .key       (key)
    );

    ds_classify u_cls (
        .seg      (seg_reg),
        .ea       (eff_addr),
        .kind_raw (acc_kind),
        .cls_raw  (instr_class),
        .key      (key),
        .res      (comb_res)
    );

    ds_out_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (comb_res),
        .q_valid  (out_valid),
        .q        (reg_res)
    );

    always_comb begin
        phys_addr    = reg_res.phys;
        full_access  = reg_res.full;
        ds_ok        = reg_res.ds_ok;
        fault        = reg_res.fault;
        fault_class  = reg_res.fcls;
        fault_status = reg_res.fstat;
        fault_addr   = reg_res.faddr;
    end

    assert_fetch_refused_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_kind == 2'd2 && seg_reg[28:20] != 9'h07F)
        |=> (fault && fault_class == 3'd1 && fault_status == 32'h1000_0000));

    assert_cache_noop_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr_class == 3'd3 && acc_kind != 2'd2 && seg_reg[28:20] != 9'h07F)
        |=> (!fault && !ds_ok && phys_addr == $past(eff_addr)));

    assert_fault_addr_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (fault ? (fault_addr == $past(eff_addr) && phys_addr == 32'h0)
                            : (fault_addr == 32'h0)));
endmodule

// File: tb/ds_seg_checker_test.sv
module ds_seg_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [31:0] phys;
        logic        full;
        logic        ok;
        logic        flt;
        logic [2:0]  fcls;
        logic [31:0] fstat;
        logic [31:0] faddr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] seg_reg = '0;
    logic [31:0] eff_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  instr_class = '0;
    logic        user_mode = 1'b0;
    logic        out_valid, full_access, ds_ok, fault;
    logic [31:0] phys_addr, fault_status, fault_addr;
    logic [2:0]  fault_class;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    ds_seg_checker uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .seg_reg(seg_reg),
        .eff_addr(eff_addr), .acc_kind(acc_kind), .instr_class(instr_class),
        .user_mode(user_mode), .out_valid(out_valid), .phys_addr(phys_addr),
        .full_access(full_access), .ds_ok(ds_ok), .fault(fault),
        .fault_class(fault_class), .fault_status(fault_status),
        .fault_addr(fault_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk_seg(logic ks, logic kp, logic [8:0] bus, logic [3:0] region);
        return {1'b1, ks, kp, bus, 16'h0000, region};
    endfunction

    function automatic exp_t model(logic [31:0] sr, logic [31:0] ea, logic [1:0] k,
                                   logic [2:0] c, logic um);
        exp_t e;
        logic st, key;
        e   = '0;
        st  = (k == 2'd1);
        key = um ? sr[29] : sr[30];
        if (sr[28:20] == 9'h07F) begin
            e.phys = {sr[3:0], ea[27:0]};
            e.full = 1'b1;
            return e;
        end
        e.faddr = ea;
        e.flt   = 1'b1;
        if (k == 2'd2) begin
            e.fcls = 3'd1; e.fstat = 32'h1000_0000;
        end else if (c == 3'd0) begin
            if (st == key) begin
                e = '0; e.phys = ea; e.ok = 1'b1;
            end else begin
                e.fcls = 3'd2; e.fstat = st ? 32'h0A00_0000 : 32'h0800_0000;
            end
        end else if (c == 3'd1) begin
            e.fcls = 3'd3;
        end else if (c == 3'd2) begin
            e.fcls = 3'd2; e.fstat = st ? 32'h0600_0000 : 32'h0400_0000;
        end else if (c == 3'd3) begin
            e = '0; e.phys = ea;
        end else if (c == 3'd4) begin
            e.fcls = 3'd2; e.fstat = st ? 32'h0610_0000 : 32'h0410_0000;
        end else begin
            e.fcls = 3'd4;
        end
        return e;
    endfunction

    task automatic send(logic [31:0] sr, logic [31:0] ea, logic [1:0] k,
                        logic [2:0] c, logic um, string tag);
        @(negedge clk);
        in_valid    = 1'b1;
        seg_reg     = sr;
        eff_addr    = ea;
        acc_kind    = k;
        instr_class = c;
        user_mode   = um;
        exp_q.push_back(model(sr, ea, k, c, um));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compares each result against the front of the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_valid) begin
                exp_t  e;
                exp_t  a;
                string t;
                a = {phys_addr, full_access, ds_ok, fault, fault_class, fault_status, fault_addr};
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R10 unexpected result act=%h exp=none", a);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (a !== e) begin
                        bad++;
                        $display("FAIL %s act=%h exp=%h", t, a, e);
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || fault !== 1'b0 || phys_addr !== 32'h0) begin
            bad++;
            $display("FAIL R10 reset act=%b/%b/%h exp=0/0/0", out_valid, fault, phys_addr);
        end
        rst = 1'b0;
        idle(1);
        // R1 memory-forced path, overrides fetch and float classes
        send(mk_seg(1'b0, 1'b0, 9'h07F, 4'hA), 32'h1234_5678, 2'd1, 3'd0, 1'b1, "R1 bypass store");
        send(mk_seg(1'b1, 1'b1, 9'h07F, 4'h3), 32'hF000_0ABC, 2'd2, 3'd1, 1'b0, "R1 bypass fetch");
        // R2 fetch refusal regardless of class
        send(mk_seg(1'b0, 1'b0, 9'h010, 4'h0), 32'h4000_1000, 2'd2, 3'd0, 1'b0, "R2 fetch int");
        send(mk_seg(1'b0, 1'b0, 9'h07E, 4'h0), 32'h4000_2000, 2'd2, 3'd3, 1'b1, "R2 fetch cache");
        // R3 floating point
        send(mk_seg(1'b0, 1'b0, 9'h020, 4'h0), 32'h5555_0004, 2'd0, 3'd1, 1'b0, "R3 float load");
        send(mk_seg(1'b1, 1'b0, 9'h020, 4'h0), 32'h5555_0008, 2'd1, 3'd1, 1'b1, "R3 float store");
        // R4 reservation
        send(mk_seg(1'b0, 1'b0, 9'h030, 4'h0), 32'h6000_0010, 2'd0, 3'd2, 1'b0, "R4 resv load");
        send(mk_seg(1'b0, 1'b0, 9'h030, 4'h0), 32'h6000_0014, 2'd1, 3'd2, 1'b0, "R4 resv store");
        // R5 external control
        send(mk_seg(1'b0, 1'b1, 9'h040, 4'h0), 32'h7000_0020, 2'd0, 3'd4, 1'b1, "R5 ext load");
        send(mk_seg(1'b0, 1'b1, 9'h040, 4'h0), 32'h7000_0024, 2'd1, 3'd4, 1'b1, "R5 ext store");
        // R6 cache management no-op
        send(mk_seg(1'b1, 1'b1, 9'h050, 4'h0), 32'h8000_0030, 2'd1, 3'd3, 1'b0, "R6 cache store");
        send(mk_seg(1'b0, 1'b0, 9'h050, 4'h0), 32'h8000_0034, 2'd3, 3'd3, 1'b1, "R6 cache kind3");
        // R7 / R8 key selection and integer gating (key bits set opposite)
        send(mk_seg(1'b1, 1'b0, 9'h060, 4'h0), 32'h9000_0040, 2'd0, 3'd0, 1'b1, "R7 R8 user load key0");
        send(mk_seg(1'b1, 1'b0, 9'h060, 4'h0), 32'h9000_0044, 2'd0, 3'd0, 1'b0, "R7 R8 sup load key1");
        send(mk_seg(1'b1, 1'b0, 9'h060, 4'h0), 32'h9000_0048, 2'd1, 3'd0, 1'b0, "R8 sup store key1");
        send(mk_seg(1'b1, 1'b0, 9'h060, 4'h0), 32'h9000_004C, 2'd1, 3'd0, 1'b1, "R8 user store key0");
        send(mk_seg(1'b0, 1'b0, 9'h07E, 4'hF), 32'h9000_0050, 2'd0, 3'd0, 1'b0, "R1 R8 near id");
        // R9 undefined classes
        send(mk_seg(1'b0, 1'b0, 9'h070, 4'h0), 32'hA000_0060, 2'd0, 3'd5, 1'b0, "R9 class5");
        send(mk_seg(1'b0, 1'b0, 9'h070, 4'h0), 32'hA000_0064, 2'd1, 3'd7, 1'b1, "R9 class7");
        idle(2);
        // R10 no result while idle
        total++;
        if (out_valid !== 1'b0 || fault !== 1'b0 || ds_ok !== 1'b0) begin
            bad++;
            $display("FAIL R10 idle act=%b/%b/%b exp=0/0/0", out_valid, fault, ds_ok);
        end
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R10 pending act=%0d exp=0", exp_q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule